// File: doc/BRIEF.md
# Command-Coded Register Access Port

This block is the host-side register port of a peripheral controller. The host does not see memory-mapped registers. It first writes an 8-bit command code with the address select line high. That code names one configuration register and a direction, read or write. The host then moves zero, one or two 16-bit data words with the address select line low. The block keeps sixteen endpoint configuration words and six other configuration registers. It drives their values straight out to the rest of the controller.

An internal word counter steps through the data phase of the current command. Any access past the word count that the command allows has no effect. A two-word register is staged, so the 32-bit value changes in one step. A dedicated command clears every register without a data phase.

Top module: `cmd_reg_port`

## Requirements
- R1: A command phase is a cycle with `cs`, `wr` and `a0` all high. Only `din[7:0]` forms the command code, `din[15:8]` is ignored, and the command itself changes no register other than through code 0xF6.
- R2: Codes 0x20 to 0x2F each take exactly one data word. That word is stored in endpoint slot `code[3:0]`, which appears on `ep_cfg[16*slot +: 16]`. Slot 0 is endpoint 0 OUT, slot 1 is endpoint 0 IN, and slots 2 to 15 are endpoints 1 to 14.
- R3: Codes 0x30 to 0x3F each allow exactly one data read, which returns endpoint slot `code[3:0]`. Read data appears on `dout` combinationally, in the same cycle as the read strobe (`cs`, `rd` high, `a0` low). A read changes no register.
- R4: Even/odd code pairs write and read one word of a single register: 0xB6/0xB7 for `dev_addr`, 0xB8/0xB9 for `mode`, 0xBA/0xBB for `hw_cfg`, 0xF0/0xF1 for `dma_cfg`, and 0xF2/0xF3 for `dma_cnt`.
- R5: Code 0xC2 writes the 32-bit `irq_en` register as two words, bits 15..0 first and then bits 31..16. Code 0xC3 reads it back in the same order.
- R6: `irq_en` changes only when the second word of a 0xC2 sequence is received. If a new command arrives after the first word, `irq_en` keeps its old value.
- R7: Data accesses beyond the word count of the current command are ignored on writes and return 0x0000 on reads.
- R8: After an unrecognised command code, data writes are dropped and data reads return 0x0000.
- R9: Code 0xF6 takes no data. On the clock edge of the command phase itself, it clears every register to zero.
- R10: A synchronous active-high `rst` clears every register to zero.
- R11: Every new command phase restarts the word counter, so reissuing 0xC3 returns bits 15..0 again.
- R12: With `cs` low, strobes have no effect.
- R13: A data write under a read code is dropped. A data read under a write code returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| a0 | input | 1 | 1 = command phase, 0 = data phase |
| wr | input | 1 | Write strobe, active high, one cycle per access |
| rd | input | 1 | Read strobe, active high, one cycle per access |
| din | input | 16 | Host write data / command code in bits 7..0 |
| dout | output | 16 | Read data; zero when no valid read is in progress |
| ep_cfg | output | 256 | Sixteen endpoint configuration words, slot n at bits 16n+15..16n |
| dev_addr | output | 16 | Device address register |
| mode | output | 16 | Mode register |
| hw_cfg | output | 16 | Hardware configuration register |
| irq_en | output | 32 | Interrupt enable register |
| dma_cfg | output | 16 | DMA configuration register |
| dma_cnt | output | 16 | DMA counter register |

## Verification
Every endpoint slot is written with a distinct pattern, under a command whose upper byte carries junk, and then read back. This separates index-decoding faults from faults in byte-lane handling. Each single-word pair is exercised with values that differ per register, which exposes swapped targets. The two-word register is tested in complete, interrupted and restarted sequences, which separates commit timing from counter-reset faults. Surplus words, mismatched directions, unknown codes, a deselected chip, the clearing command and the reset input each confirm that nothing else moved.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_EP,
    TGT_ADDR,
    TGT_MODE,
    TGT_HWCFG,
    TGT_IRQEN,
    TGT_DMACFG,
    TGT_DMACNT
  } tgt_e;

  localparam logic [7:0] CODE_CLEAR = 8'hF6;

  typedef struct packed {
    tgt_e       tgt;
    logic [3:0] idx;
    logic       rd;
    logic [1:0] nwords;
    logic       clear;
  } cmd_s;

  function automatic cmd_s decode_cmd(input logic [7:0] c);
    cmd_s r;
    r.tgt    = TGT_NONE;
    r.idx    = c[3:0];
    r.rd     = c[0];
    r.nwords = 2'd1;
    r.clear  = 1'b0;
    if (c[7:4] == 4'h2) begin
      r.tgt = TGT_EP;
      r.rd  = 1'b0;
    end else if (c[7:4] == 4'h3) begin
      r.tgt = TGT_EP;
      r.rd  = 1'b1;
    end else begin
      case (c[7:1])
        7'h5B:   r.tgt = TGT_ADDR;
        7'h5C:   r.tgt = TGT_MODE;
        7'h5D:   r.tgt = TGT_HWCFG;
        7'h61: begin
          r.tgt    = TGT_IRQEN;
          r.nwords = 2'd2;
        end
        7'h78:   r.tgt = TGT_DMACFG;
        7'h79:   r.tgt = TGT_DMACNT;
        default: r.nwords = 2'd0;
      endcase
    end
    if (c == CODE_CLEAR) r.clear = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode
  import cmdport_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  output cmd_s              dec
);
  always_comb dec = decode_cmd(code);
endmodule

// File: rtl/cmdport_seq.sv
module cmdport_seq
  import cmdport_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              dwr,
  input  logic              drd,
  input  logic [DW-1:0]     din,
  output tgt_e              tgt,
  output logic [3:0]        idx,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              word_hi,
  output logic [DW-1:0]     stage,
  output logic              clear
);
  localparam logic [1:0] CNT_MAX = 2'd3;

  cmd_s       dec;
  tgt_e       cur_tgt;
  logic [3:0] cur_idx;
  logic       cur_rd;
  logic [1:0] cur_nw;
  logic [1:0] cnt;
  logic       in_win;

  cmdport_decode #(.CODE_W(CODE_W)) u_dec (
    .code (cmd_code),
    .dec  (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_tgt <= TGT_NONE;
      cur_idx <= '0;
      cur_rd  <= 1'b0;
      cur_nw  <= 2'd0;
      cnt     <= 2'd0;
      stage   <= '0;
    end else if (cmd_stb) begin
      cur_tgt <= dec.tgt;
      cur_idx <= dec.idx;
      cur_rd  <= dec.rd;
      cur_nw  <= dec.nwords;
      cnt     <= 2'd0;
    end else if (dwr || drd) begin
      if (cnt != CNT_MAX) cnt <= cnt + 2'd1;
      if (wr_ok && cnt == 2'd0) stage <= din;
    end
  end

  assign in_win  = (cnt < cur_nw);
  assign wr_ok   = dwr && !cur_rd && in_win;
  assign rd_ok   = drd && cur_rd && in_win;
  assign word_hi = cnt[0];
  assign tgt     = cur_tgt;
  assign idx     = cur_idx;
  assign clear   = cmd_stb && dec.clear;
endmodule

// File: rtl/cmdport_regs.sv
module cmdport_regs
  import cmdport_pkg::*;
#(
  parameter int DW     = 16,
  parameter int EP_NUM = 16
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               wr_ok,
  input  tgt_e               tgt,
  input  logic [3:0]         idx,
  input  logic               word_hi,
  input  logic [DW-1:0]      din,
  input  logic [DW-1:0]      stage,
  output logic [EP_NUM*DW-1:0] ep_flat,
  output logic [DW-1:0]      dev_addr,
  output logic [DW-1:0]      mode,
  output logic [DW-1:0]      hw_cfg,
  output logic [2*DW-1:0]    irq_en,
  output logic [DW-1:0]      dma_cfg,
  output logic [DW-1:0]      dma_cnt,
  output logic [DW-1:0]      rd_word
);
  localparam int EP_IW = (EP_NUM > 1) ? $clog2(EP_NUM) : 1;

  logic [DW-1:0] ep_q [EP_NUM];
  logic          ep_we;

  assign ep_we = wr_ok && (tgt == TGT_EP);

  for (genvar g = 0; g < EP_NUM; g++) begin : g_ep
    always_ff @(posedge clk) begin
      if (clr) ep_q[g] <= '0;
      else if (ep_we && idx[EP_IW-1:0] == EP_IW'(g)) ep_q[g] <= din;
    end
    assign ep_flat[g*DW +: DW] = ep_q[g];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      dev_addr <= '0;
      mode     <= '0;
      hw_cfg   <= '0;
      irq_en   <= '0;
      dma_cfg  <= '0;
      dma_cnt  <= '0;
    end else if (wr_ok) begin
      case (tgt)
        TGT_ADDR:   dev_addr <= din;
        TGT_MODE:   mode     <= din;
        TGT_HWCFG:  hw_cfg   <= din;
        TGT_DMACFG: dma_cfg  <= din;
        TGT_DMACNT: dma_cnt  <= din;
        TGT_IRQEN:  if (word_hi) irq_en <= {din, stage};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (tgt)
      TGT_EP:     rd_word = ep_q[idx[EP_IW-1:0]];
      TGT_ADDR:   rd_word = dev_addr;
      TGT_MODE:   rd_word = mode;
      TGT_HWCFG:  rd_word = hw_cfg;
      TGT_IRQEN:  rd_word = word_hi ? irq_en[2*DW-1:DW] : irq_en[DW-1:0];
      TGT_DMACFG: rd_word = dma_cfg;
      TGT_DMACNT: rd_word = dma_cnt;
      default:    rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cmd_reg_port.sv
module cmd_reg_port
  import cmdport_pkg::*;
#(
  parameter int DW     = 16,
  parameter int EP_NUM = 16,
  parameter int CODE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs,
  input  logic                 a0,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [DW-1:0]        din,
  output logic [DW-1:0]        dout,
  output logic [EP_NUM*DW-1:0] ep_cfg,
  output logic [DW-1:0]        dev_addr,
  output logic [DW-1:0]        mode,
  output logic [DW-1:0]        hw_cfg,
  output logic [2*DW-1:0]      irq_en,
  output logic [DW-1:0]        dma_cfg,
  output logic [DW-1:0]        dma_cnt
);
  logic          cmd_stb, dwr, drd;
  tgt_e          tgt;
  logic [3:0]    idx;
  logic          wr_ok, rd_ok, word_hi, clear;
  logic [DW-1:0] stage, rd_word;

  assign cmd_stb = cs && wr && a0;
  assign dwr     = cs && wr && !a0;
  assign drd     = cs && rd && !wr && !a0;

  cmdport_seq #(.DW(DW), .CODE_W(CODE_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_stb  (cmd_stb),
    .cmd_code (din[CODE_W-1:0]),
    .dwr      (dwr),
    .drd      (drd),
    .din      (din),
    .tgt      (tgt),
    .idx      (idx),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .word_hi  (word_hi),
    .stage    (stage),
    .clear    (clear)
  );

  cmdport_regs #(.DW(DW), .EP_NUM(EP_NUM)) u_regs (
    .clk      (clk),
    .clr      (rst || clear),
    .wr_ok    (wr_ok),
    .tgt      (tgt),
    .idx      (idx),
    .word_hi  (word_hi),
    .din      (din),
    .stage    (stage),
    .ep_flat  (ep_cfg),
    .dev_addr (dev_addr),
    .mode     (mode),
    .hw_cfg   (hw_cfg),
    .irq_en   (irq_en),
    .dma_cfg  (dma_cfg),
    .dma_cnt  (dma_cnt),
    .rd_word  (rd_word)
  );

  assign dout = rd_ok ? rd_word : '0;
endmodule

// File: rtl/cmdport_checker.sv
module cmdport_checker #(
  parameter int DW     = 16,
  parameter int EP_NUM = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs,
  input logic                 a0,
  input logic                 wr,
  input logic                 rd,
  input logic [DW-1:0]        din,
  input logic [DW-1:0]        dout,
  input logic [EP_NUM*DW-1:0] ep_cfg,
  input logic [DW-1:0]        dev_addr,
  input logic [DW-1:0]        mode,
  input logic [DW-1:0]        hw_cfg,
  input logic [2*DW-1:0]      irq_en,
  input logic [DW-1:0]        dma_cfg,
  input logic [DW-1:0]        dma_cnt
);
  logic all_zero;
  assign all_zero = (ep_cfg == '0) && (dev_addr == '0) && (mode == '0) &&
                    (hw_cfg == '0) && (irq_en == '0) && (dma_cfg == '0) &&
                    (dma_cnt == '0);

  AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && a0 && din[7:0] == 8'hF6) |=> all_zero); // R9

  AST_HW_RESET: assert property (@(posedge clk)
    rst |=> all_zero); // R10

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr) |=> $stable(irq_en)); // R6

  AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && a0 && din[7:0] != 8'hF6) |=> ($stable(ep_cfg) && $stable(dev_addr) &&
      $stable(mode) && $stable(hw_cfg) && $stable(irq_en) && $stable(dma_cfg) &&
      $stable(dma_cnt))); // R1

  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!wr) |=> ($stable(ep_cfg) && $stable(dev_addr) && $stable(mode) &&
      $stable(hw_cfg) && $stable(dma_cfg) && $stable(dma_cnt))); // R3

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (dout == '0)); // R12
endmodule

bind cmd_reg_port cmdport_checker #(.DW(DW), .EP_NUM(EP_NUM)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .a0(a0), .wr(wr), .rd(rd), .din(din),
  .dout(dout), .ep_cfg(ep_cfg), .dev_addr(dev_addr), .mode(mode),
  .hw_cfg(hw_cfg), .irq_en(irq_en), .dma_cfg(dma_cfg), .dma_cnt(dma_cnt)
);

// File: tb/cmd_reg_port_bench.sv
`timescale 1ns/1ps
module cmd_reg_port_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs = 1'b0, a0 = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [15:0]  din = '0;
  logic [15:0]  dout;
  logic [255:0] ep_cfg;
  logic [15:0]  dev_addr, mode, hw_cfg, dma_cfg, dma_cnt;
  logic [31:0]  irq_en;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  cmd_reg_port u_cmd_reg_port (
    .clk(clk), .rst(rst), .cs(cs), .a0(a0), .wr(wr), .rd(rd), .din(din),
    .dout(dout), .ep_cfg(ep_cfg), .dev_addr(dev_addr), .mode(mode),
    .hw_cfg(hw_cfg), .irq_en(irq_en), .dma_cfg(dma_cfg), .dma_cnt(dma_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit sel, input bit cmd, input bit w,
                        input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    cs = sel; a0 = cmd; wr = w; rd = !w; din = d;
    #1 q = dout;
    @(negedge clk);
    cs = 1'b0; a0 = 1'b0; wr = 1'b0; rd = 1'b0; din = '0;
  endtask

  task automatic cmd(input logic [15:0] c);
    logic [15:0] q;
    access(1'b1, 1'b1, 1'b1, c, q);
  endtask

  task automatic wdat(input logic [15:0] d);
    logic [15:0] q;
    access(1'b1, 1'b0, 1'b1, d, q);
  endtask

  task automatic rdat(output logic [15:0] q);
    access(1'b1, 1'b0, 1'b0, 16'h0, q);
  endtask

  function automatic bit all_zero();
    return ep_cfg == '0 && dev_addr == 0 && mode == 0 && hw_cfg == 0 &&
           irq_en == 0 && dma_cfg == 0 && dma_cnt == 0;
  endfunction

  task automatic t_reset_state();
    chk(all_zero(), "R10 reset clears", {16'h0, dev_addr}, 32'h0);
    chk(dout == 16'h0, "R10 dout idle", {16'h0, dout}, 32'h0);
  endtask

  task automatic t_endpoints();
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v = 16'h1000 + 16'(i) * 16'h0111;
      cmd({8'hA5, 8'h20 + 8'(i)});
      wdat(v);
      chk(ep_cfg[16*i +: 16] == v, "R2 endpoint write", {16'h0, ep_cfg[16*i +: 16]}, {16'h0, v});
    end
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v = 16'h1000 + 16'(i) * 16'h0111;
      cmd({8'h5A, 8'h30 + 8'(i)});
      rdat(rv);
      chk(rv == v, "R3 endpoint read", {16'h0, rv}, {16'h0, v});
    end
    chk(ep_cfg[15:0] == 16'h1000, "R1 upper byte ignored", {16'h0, ep_cfg[15:0]}, 32'h1000);
  endtask

  task automatic t_single();
    logic [7:0]  codes [5] = '{8'hB6, 8'hB8, 8'hBA, 8'hF0, 8'hF2};
    logic [15:0] vals  [5] = '{16'h0042, 16'hC3A1, 16'h5E17, 16'h9001, 16'h7FFE};
    for (int i = 0; i < 5; i++) begin
      cmd({8'h00, codes[i]});
      wdat(vals[i]);
    end
    chk(dev_addr == 16'h0042, "R4 dev_addr", {16'h0, dev_addr}, 32'h0042);
    chk(mode == 16'hC3A1, "R4 mode", {16'h0, mode}, 32'hC3A1);
    chk(hw_cfg == 16'h5E17, "R4 hw_cfg", {16'h0, hw_cfg}, 32'h5E17);
    chk(dma_cfg == 16'h9001, "R4 dma_cfg", {16'h0, dma_cfg}, 32'h9001);
    chk(dma_cnt == 16'h7FFE, "R4 dma_cnt", {16'h0, dma_cnt}, 32'h7FFE);
    for (int i = 0; i < 5; i++) begin
      cmd({8'h00, codes[i] | 8'h01});
      rdat(rv);
      chk(rv == vals[i], "R4 readback", {16'h0, rv}, {16'h0, vals[i]});
    end
  endtask

  task automatic t_irq();
    cmd(16'h00C2);
    wdat(16'h1234);
    chk(irq_en == 32'h0, "R6 no update after first word", irq_en, 32'h0);
    wdat(16'hABCD);
    chk(irq_en == 32'hABCD1234, "R5 two-word write", irq_en, 32'hABCD1234);
    cmd(16'h00C3);
    rdat(rv);
    chk(rv == 16'h1234, "R5 read low word", {16'h0, rv}, 32'h1234);
    rdat(rv);
    chk(rv == 16'hABCD, "R5 read high word", {16'h0, rv}, 32'hABCD);
    rdat(rv);
    chk(rv == 16'h0, "R7 surplus read", {16'h0, rv}, 32'h0);
    cmd(16'h00C2);
    wdat(16'h5555);
    cmd(16'h00B7);
    wdat(16'h6666);
    chk(irq_en == 32'hABCD1234, "R6 interrupted write", irq_en, 32'hABCD1234);
  endtask

  task automatic t_restart();
    cmd(16'h00C3);
    rdat(rv);
    cmd(16'h00C3);
    rdat(rv);
    chk(rv == 16'h1234, "R11 counter restart", {16'h0, rv}, 32'h1234);
  endtask

  task automatic t_surplus();
    cmd(16'h00B6);
    wdat(16'h0011);
    wdat(16'h0022);
    chk(dev_addr == 16'h0011, "R7 surplus write", {16'h0, dev_addr}, 32'h0011);
  endtask

  task automatic t_unknown();
    cmd(16'h0055);
    wdat(16'hDEAD);
    chk(dev_addr == 16'h0011 && mode == 16'hC3A1 && irq_en == 32'hABCD1234,
        "R8 unknown write dropped", {16'h0, dev_addr}, 32'h0011);
    rdat(rv);
    chk(rv == 16'h0, "R8 unknown read zero", {16'h0, rv}, 32'h0);
  endtask

  task automatic t_direction();
    logic [15:0] q;
    cmd(16'h0020);
    rdat(rv);
    chk(rv == 16'h0, "R13 read under write code", {16'h0, rv}, 32'h0);
    cmd(16'h0030);
    wdat(16'hBEEF);
    chk(ep_cfg[15:0] == 16'h1000, "R13 write under read code", {16'h0, ep_cfg[15:0]}, 32'h1000);
    cmd(16'h00B6);
    access(1'b0, 1'b0, 1'b1, 16'h7777, q);
    chk(dev_addr == 16'h0011, "R12 deselected write", {16'h0, dev_addr}, 32'h0011);
    cmd(16'h00B7);
    access(1'b0, 1'b0, 1'b0, 16'h0, q);
    chk(q == 16'h0, "R12 deselected read", {16'h0, q}, 32'h0);
  endtask

  task automatic t_clear_cmd();
    cmd(16'h00F6);
    chk(all_zero(), "R9 clear command", irq_en, 32'h0);
    wdat(16'h4321);
    chk(all_zero(), "R9 no data phase", {16'h0, dev_addr}, 32'h0);
  endtask

  task automatic t_hw_reset();
    cmd(16'h00B8);
    wdat(16'h0F0F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(all_zero(), "R10 reset input", {16'h0, mode}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_endpoints();
    t_single();
    t_irq();
    t_restart();
    t_surplus();
    t_unknown();
    t_direction();
    t_clear_cmd();
    t_hw_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule